// File: doc/BRIEF.md
# Warp Divergence Mask Sequencer

This block steers a warp of 32 threads that share one fetch and decode path. Each cycle in which the warp issues an instruction, the block computes the next program counter and the set of lanes that take part in it. A non-branch instruction moves the counter forward by a fixed step. A conditional branch arrives with a per-lane taken vector, a jump target and the program counter where the two sides meet again. Lanes that are currently suspended have no vote. If every participating lane agrees, the warp simply follows that direction with the same lanes active.

When the participating lanes disagree, the block runs the two sides one after the other. It saves two records on a bounded stack. The first holds the meeting point and the full lane set from before the branch. The second holds the fall-through address and the lanes that did not take the branch. The warp then continues at the target with only the taking lanes. Whenever the next counter reaches the meeting point stored on top of the stack, the top record is removed and the warp resumes from its address with its lanes. So the fall-through side runs next, and after that the full lane set comes back at the meeting point. If the resumed address is itself the meeting point of the record now on top, that record is removed in the same cycle. This covers a branch whose fall-through is the meeting point, and nested branches that meet at the same place.

Thread t runs in lane t mod 32 of warp t / 32. The block sees only lanes. Fetch, the execution lanes and the choice between warps are handled elsewhere.

Top module: `simt_warp_seq`

## Requirements
- R1: After reset, warp_pc equals RESET_PC (0), active_mask is all ones, and stack_ovf is 0.
- R2: An issued non-branch instruction advances warp_pc by PC_STEP (4) on the next cycle and leaves active_mask unchanged, unless a reconvergence pop applies (R6 to R8).
- R3: An issued branch on which every active lane is taken sets warp_pc to br_target and keeps active_mask. Bits of br_taken for inactive lanes are ignored.
- R4: An issued branch on which no active lane is taken advances warp_pc by PC_STEP and keeps active_mask.
- R5: An issued branch with both taken and not-taken active lanes sets warp_pc to br_target and active_mask to (active_mask AND br_taken). It pushes two records: first the reconvergence PC with the old full mask, then the fall-through PC with (active_mask AND NOT br_taken). Both records use the reconvergence PC as their pop trigger.
- R6: When an issued instruction that pushes nothing would move warp_pc to the top record's trigger, that record is popped, and warp_pc and active_mask take its stored address and mask. After a divergent branch, this starts the not-taken side.
- R7: When the not-taken side reaches the reconvergence PC, the reconvergence record is popped: warp_pc becomes the reconvergence PC and active_mask becomes the mask from before the branch.
- R8: If the address resumed by a pop equals the trigger of the record below it, both records are popped in the same cycle, and the lower record's address and mask are used.
- R9: The stack holds DEPTH (8) records. A divergent branch that finds fewer than two free records pushes nothing, sets stack_ovf, and continues at br_target with the taken lanes.
- R10: Once set, stack_ovf stays 1 until reset.
- R11: With issue_valid low, warp_pc and active_mask hold their values.
- R12: Nested divergent branches unwind in last-in first-out order. The masks saved at each level come back as the inner levels reconverge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | The warp issues its current instruction this cycle |
| issue_is_branch | input | 1 | The issued instruction is a conditional branch |
| br_taken | input | 32 | Per-lane branch outcome, 1 = taken |
| br_target | input | 32 | Address of the taken side |
| br_reconv | input | 32 | Address where both sides meet again |
| warp_pc | output | 32 | Program counter of the next instruction for the warp |
| active_mask | output | 32 | Lanes taking part in the next instruction |
| stack_ovf | output | 1 | Sticky flag for a push that did not fit |

## Verification
The assertions take three things for granted about the inputs. A divergent branch never has its target equal to its reconvergence PC. Nested branches reconverge in last-in first-out order. No more than two stacked records share one trigger along a single pop chain. The random stimulus places every target and reconvergence PC a positive number of steps after the branch, with the reconvergence PC strictly beyond the target. The nesting test gives inner levels meeting points that come before those of the outer levels. The only case where a resumed address matches the next trigger is the directed test for R8.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;

  typedef enum logic [1:0] {
    BK_SEQ   = 2'd0,
    BK_ALL_T = 2'd1,
    BK_ALL_N = 2'd2,
    BK_SPLIT = 2'd3
  } br_kind_e;

  // classify an issued instruction from the effective lane votes
  function automatic br_kind_e kind_of(input logic is_br, input logic any_t, input logic any_n);
    if (!is_br) return BK_SEQ;
    if (any_t && any_n) return BK_SPLIT;
    if (any_t) return BK_ALL_T;
    return BK_ALL_N;
  endfunction

  // true when a stack of 'depth' records at level 'lvl' has room for two more
  function automatic logic fits_two(input int unsigned lvl, input int unsigned depth);
    return (lvl + 2) <= depth;
  endfunction

endpackage

// File: rtl/simt_branch_split.sv
module simt_branch_split
  import simt_div_pkg::*;
#(
  parameter int unsigned LANES = 32
) (
  input  logic             is_branch,
  input  logic [LANES-1:0] cur_mask,
  input  logic [LANES-1:0] taken,
  output logic [LANES-1:0] taken_eff,
  output logic [LANES-1:0] rest_eff,
  output br_kind_e         kind
);

  always_comb begin
    taken_eff = cur_mask & taken;
    rest_eff  = cur_mask & ~taken;
    kind      = kind_of(is_branch, |taken_eff, |rest_eff);
  end

endmodule

// File: rtl/simt_recon_stack.sv
module simt_recon_stack
  import simt_div_pkg::*;
#(
  parameter int unsigned LANES = 32,
  parameter int unsigned PCW   = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push2,
  input  logic [PCW-1:0]             lo_resume,
  input  logic [PCW-1:0]             lo_trig,
  input  logic [LANES-1:0]           lo_mask,
  input  logic [PCW-1:0]             hi_resume,
  input  logic [PCW-1:0]             hi_trig,
  input  logic [LANES-1:0]           hi_mask,
  input  logic [1:0]                 pop_cnt,
  output logic [PCW-1:0]             top_resume,
  output logic [PCW-1:0]             top_trig,
  output logic [LANES-1:0]           top_mask,
  output logic [PCW-1:0]             sec_resume,
  output logic [PCW-1:0]             sec_trig,
  output logic [LANES-1:0]           sec_mask,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       room2
);

  localparam int unsigned SPW = $clog2(DEPTH + 1);
  localparam int unsigned IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PCW-1:0]   res_q [DEPTH];
  logic [PCW-1:0]   trg_q [DEPTH];
  logic [LANES-1:0] msk_q [DEPTH];
  logic [SPW-1:0]   sp_q;

  logic [IW-1:0] lo_idx, hi_idx, top_idx, sec_idx;

  always_comb begin
    lo_idx  = IW'(sp_q);
    hi_idx  = IW'(sp_q + SPW'(1));
    top_idx = IW'(sp_q - SPW'(1));
    sec_idx = IW'(sp_q - SPW'(2));
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic wr_lo, wr_hi;
    assign wr_lo = push2 && (lo_idx == IW'(e));
    assign wr_hi = push2 && (hi_idx == IW'(e));
    always_ff @(posedge clk) begin
      if (wr_lo) begin
        res_q[e] <= lo_resume;
        trg_q[e] <= lo_trig;
        msk_q[e] <= lo_mask;
      end else if (wr_hi) begin
        res_q[e] <= hi_resume;
        trg_q[e] <= hi_trig;
        msk_q[e] <= hi_mask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sp_q <= '0;
    else if (push2) sp_q <= sp_q + SPW'(2);
    else sp_q <= sp_q - SPW'(pop_cnt);
  end

  always_comb begin
    top_resume = res_q[top_idx];
    top_trig   = trg_q[top_idx];
    top_mask   = msk_q[top_idx];
    sec_resume = res_q[sec_idx];
    sec_trig   = trg_q[sec_idx];
    sec_mask   = msk_q[sec_idx];
    level      = sp_q;
    room2      = fits_two(int'(sp_q), DEPTH);
  end

  // R9: the stack pointer never runs past its capacity
  p_sp_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sp_q) <= DEPTH);
  // R9: a double push is only requested when two records are free
  p_push_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push2 |-> room2);
  // R6: a pop never removes more records than are held
  p_pop_avail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop_cnt) <= int'(sp_q));
  // R5: a push and a pop never meet in one cycle
  p_push_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push2 |-> pop_cnt == 2'd0);

endmodule

// File: rtl/simt_warp_seq.sv
module simt_warp_seq
  import simt_div_pkg::*;
#(
  parameter int unsigned LANES    = 32,
  parameter int unsigned PCW      = 32,
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned PC_STEP  = 4,
  parameter int unsigned RESET_PC = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic             issue_is_branch,
  input  logic [LANES-1:0] br_taken,
  input  logic [PCW-1:0]   br_target,
  input  logic [PCW-1:0]   br_reconv,
  output logic [PCW-1:0]   warp_pc,
  output logic [LANES-1:0] active_mask,
  output logic             stack_ovf
);

  localparam int unsigned SPW = $clog2(DEPTH + 1);

  logic [PCW-1:0]   pc_q;
  logic [LANES-1:0] mask_q;
  logic             ovf_q;

  logic [LANES-1:0] taken_eff, rest_eff;
  br_kind_e         kind;

  logic [PCW-1:0]   top_resume, top_trig, sec_resume, sec_trig;
  logic [LANES-1:0] top_mask, sec_mask;
  logic [SPW-1:0]   level;
  logic             room2;

  // named internal events
  logic             is_split, do_push, ovf_hit, pop1, pop2;
  logic [1:0]       pop_cnt;
  logic [PCW-1:0]   seq_pc, cand_pc, pc_d;
  logic [LANES-1:0] mask_d;

  simt_branch_split #(.LANES(LANES)) u_split (
    .is_branch (issue_is_branch),
    .cur_mask  (mask_q),
    .taken     (br_taken),
    .taken_eff (taken_eff),
    .rest_eff  (rest_eff),
    .kind      (kind)
  );

  simt_recon_stack #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push2      (do_push),
    .lo_resume  (br_reconv),
    .lo_trig    (br_reconv),
    .lo_mask    (mask_q),
    .hi_resume  (seq_pc),
    .hi_trig    (br_reconv),
    .hi_mask    (rest_eff),
    .pop_cnt    (pop_cnt),
    .top_resume (top_resume),
    .top_trig   (top_trig),
    .top_mask   (top_mask),
    .sec_resume (sec_resume),
    .sec_trig   (sec_trig),
    .sec_mask   (sec_mask),
    .level      (level),
    .room2      (room2)
  );

  always_comb begin
    seq_pc   = pc_q + PCW'(PC_STEP);
    is_split = issue_valid && (kind == BK_SPLIT);
    do_push  = is_split && room2;
    ovf_hit  = is_split && !room2;
    cand_pc  = (kind == BK_SPLIT || kind == BK_ALL_T) ? br_target : seq_pc;
    pop1     = issue_valid && !do_push && (level != '0) && (cand_pc == top_trig);
    pop2     = pop1 && (int'(level) >= 2) && (top_resume == sec_trig);
    pop_cnt  = pop2 ? 2'd2 : (pop1 ? 2'd1 : 2'd0);

    pc_d   = pc_q;
    mask_d = mask_q;
    if (issue_valid) begin
      if (pop2) begin
        pc_d   = sec_resume;
        mask_d = sec_mask;
      end else if (pop1) begin
        pc_d   = top_resume;
        mask_d = top_mask;
      end else begin
        pc_d   = cand_pc;
        mask_d = is_split ? taken_eff : mask_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= PCW'(RESET_PC);
      mask_q <= '1;
      ovf_q  <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      mask_q <= mask_d;
      if (ovf_hit) ovf_q <= 1'b1;
    end
  end

  assign warp_pc     = pc_q;
  assign active_mask = mask_q;
  assign stack_ovf   = ovf_q;

  // R5: a pushed split leaves only the taken lanes running
  p_split_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> active_mask == $past(taken_eff));
  // R5: at least one lane is always active
  p_mask_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active_mask != '0);
  // R3: a uniform branch without a pop keeps the lane set
  p_uniform_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && (kind == BK_ALL_T || kind == BK_ALL_N) && !pop1 |=> $stable(active_mask));
  // R2: without a pop the lane set can only shrink
  p_mask_shrink_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pop1 |=> (active_mask & ~$past(active_mask)) == '0);
  // R10: the overflow flag is sticky
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stack_ovf |=> stack_ovf);
  // R9: the flag rises only on a split that did not fit
  p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stack_ovf) |-> $past(ovf_hit));
  // R11: no issue, no change
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> $stable(warp_pc) && $stable(active_mask));

endmodule

// File: tb/simt_warp_seq_tb.sv
module simt_warp_seq_tb;

  localparam int unsigned STEP = 4;
  localparam int unsigned DEP  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic        issue_is_branch = 1'b0;
  logic [31:0] br_taken = '0;
  logic [31:0] br_target = '0;
  logic [31:0] br_reconv = '0;
  logic [31:0] warp_pc;
  logic [31:0] active_mask;
  logic        stack_ovf;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // bench-side model state
  logic [31:0] m_res [DEP];
  logic [31:0] m_trg [DEP];
  logic [31:0] m_msk [DEP];
  int          m_sp;
  logic [31:0] m_pc;
  logic [31:0] m_mask;
  logic        m_ovf;

  always #5 clk = ~clk;

  simt_warp_seq u_dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_is_branch(issue_is_branch),
    .br_taken(br_taken), .br_target(br_target), .br_reconv(br_reconv),
    .warp_pc(warp_pc), .active_mask(active_mask), .stack_ovf(stack_ovf)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic lanes_split(input logic [31:0] m, input logic [31:0] t);
    return ((m & t) != 0) && ((m & ~t) != 0);
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (warp_pc !== m_pc || active_mask !== m_mask || stack_ovf !== m_ovf) begin
      errors++;
      $display("FAIL %s: pc=%h mask=%h ovf=%b expected pc=%h mask=%h ovf=%b",
               tag, warp_pc, active_mask, stack_ovf, m_pc, m_mask, m_ovf);
    end
  endtask

  // spec model of one issue; returns the requirement the cycle exercises
  task automatic model_step(input logic iv, input logic br, input logic [31:0] tk,
                            input logic [31:0] tg, input logic [31:0] rc, output string tag);
    logic [31:0] cand;
    logic [31:0] nmask;
    logic        pushed;
    logic [31:0] r;
    if (!iv) begin tag = "R11"; return; end
    pushed = 1'b0;
    nmask  = m_mask;
    cand   = m_pc + STEP;
    tag    = "R2";
    if (br) begin
      if ((m_mask & tk) == 0) tag = "R4";
      else if (!lanes_split(m_mask, tk)) begin cand = tg; tag = "R3"; end
      else begin
        cand  = tg;
        nmask = m_mask & tk;
        if (m_sp + 2 <= DEP) begin
          m_res[m_sp] = rc; m_trg[m_sp] = rc; m_msk[m_sp] = m_mask;
          m_res[m_sp+1] = m_pc + STEP; m_trg[m_sp+1] = rc; m_msk[m_sp+1] = m_mask & ~tk;
          m_sp  = m_sp + 2;
          pushed = 1'b1;
          tag = "R5";
        end else begin
          m_ovf = 1'b1;
          tag = "R9";
        end
      end
    end
    if (!pushed && m_sp > 0 && cand == m_trg[m_sp-1]) begin
      r = m_res[m_sp-1];
      tag = (r == m_trg[m_sp-1]) ? "R7" : "R6";
      cand = r; nmask = m_msk[m_sp-1];
      m_sp = m_sp - 1;
      if (m_sp > 0 && r == m_trg[m_sp-1]) begin
        cand = m_res[m_sp-1]; nmask = m_msk[m_sp-1];
        m_sp = m_sp - 1;
        tag = "R8";
      end
    end
    m_pc = cand;
    m_mask = nmask;
  endtask

  // one cycle: starts and ends at a falling edge
  task automatic cycle(input logic iv, input logic br, input logic [31:0] tk,
                       input logic [31:0] tg, input logic [31:0] rc, input string force_tag);
    string tag;
    issue_valid = iv; issue_is_branch = br; br_taken = tk; br_target = tg; br_reconv = rc;
    model_step(iv, br, tk, tg, rc, tag);
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; issue_valid = 1'b0; issue_is_branch = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    m_sp = 0; m_pc = 32'h0; m_mask = '1; m_ovf = 1'b0;
    compare("R1");
  endtask

  initial begin
    void'($urandom(32'd2024));
    do_reset();

    // directed corner cases
    cycle(0, 0, '0, '0, '0, "R11");
    cycle(1, 0, '0, '0, '0, "R2");
    cycle(1, 1, '1, 32'h40, 32'h50, "R3");
    cycle(1, 1, '0, 32'h90, 32'hA0, "R4");
    cycle(1, 1, 32'h0000FFFF, 32'h60, 32'h80, "R5");
    cycle(1, 1, 32'hFFFF0000, 32'h20, 32'h30, "R3");   // only inactive lanes vote taken
    while (m_pc != 32'h48 && m_sp == 2) cycle(1, 0, '0, '0, '0, "");  // ends with R6 pop
    while (m_sp != 0) cycle(1, 0, '0, '0, '0, "");                    // ends with R7 pop
    // fall-through equals reconvergence point: double pop on return
    cycle(1, 1, 32'hF0F0F0F0, 32'h100, m_pc + STEP, "R5");
    cycle(1, 1, '1, m_pc - 32'h7C, 32'h0, "R8");
    // nesting past capacity
    for (int k = 0; k < 5; k++)
      cycle(1, 1, active_mask & ~(32'h1 << k), m_pc + 8, 32'h800 - 32'h40 * k, (k == 4) ? "R9" : "R12");
    cycle(1, 0, '0, '0, '0, "R10");
    for (int g = 0; g < 6000 && m_sp != 0; g++) cycle(1, 0, '0, '0, '0, "R12");
    cycle(1, 0, '0, '0, '0, "R10");
    do_reset();

    // constrained random phases
    for (int ph = 0; ph < 4; ph++) begin
      for (int n = 0; n < 3000; n++) begin
        logic        iv, br;
        logic [31:0] tk, tg, rc;
        int          sel;
        iv  = ($urandom_range(0, 99) < 85);
        br  = ($urandom_range(0, 99) < 25);
        sel = $urandom_range(0, 3);
        tk  = (sel == 0) ? '1 : (sel == 1) ? '0 : (sel == 2) ? $urandom() : ($urandom() & 32'h0F0F00FF);
        tg  = m_pc + STEP * $urandom_range(1, 6);
        rc  = tg + STEP * $urandom_range(1, 6);
        cycle(iv, br, tk, tg, rc, "");
      end
      do_reset();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule